// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block turns one asynchronous external pin into an interrupt request. The pin is brought into the clock domain and watched for a chosen event. The event can be a falling edge, a rising edge, a low level or a high level. A one-byte control and status register selects which event counts. It also enables the pin as a source, gates the request output and holds a pending flag. Software clears that flag by writing a one to a separate acknowledge bit.

The pending flag is kept through a general reset, so a request caught before that reset can still be seen afterwards. Only a power-on reset clears it. Rising-edge and high-level detection are honoured only while the run-mode input is high. Falling-edge and low-level detection work in every mode.

Top module: `pinirq_ctrl`

## Requirements
- R1: While `por` is high, and after it is released, `rd_data` reads 0x00 and `irq` is 0. Every control bit and the pending flag are cleared.
- R2: A general reset (`rst` high with `por` low) clears every control bit but leaves the pending flag unchanged. With the enable bit cleared, `irq` reads 0.
- R3: The register has this layout: bit 5 is polarity, bit 4 is pin enable, bit 3 is the pending flag, bit 2 is acknowledge, bit 1 is interrupt enable and bit 0 is detection mode. Bits 7:6 and bit 2 always read 0. A write sets bits 5, 4, 1 and 0 from `wr_data`, and the new value is visible on the next cycle.
- R4: With polarity 0 and mode 0, a falling edge on `pin_async` sets the flag on the third rising clock edge after the pin changes.
- R5: With polarity 1, mode 0 and `run_mode` high, a rising edge on the pin sets the flag with the same latency.
- R6: With polarity 1 and `run_mode` low, no edge and no level on the pin sets the flag.
- R7: With mode 1, the active level sets the flag. If the level is still present when an acknowledge is written, the flag is set again by the next clock.
- R8: While pin enable is 0, no activity on the pin sets the flag.
- R9: Writing either value to bit 3 does not change the flag. A write with bit 2 = 0 does not clear it. A write with bit 2 = 1 clears it on the next cycle.
- R10: If a detection event and an acknowledge write fall in the same cycle, the flag stays set.
- R11: `irq` is 1 exactly when both the flag and the interrupt-enable bit are 1.
- R12: In edge mode (mode 0), a level that is still held after an acknowledge does not set the flag again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high; clears everything |
| rst | input | 1 | General reset, synchronous, active high; keeps the pending flag |
| run_mode | input | 1 | High while the system is in run mode |
| pin_async | input | 1 | External interrupt pin, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the collision of a detection event with an acknowledge write in the same clock. The event appears only after the pin has passed through the synchronizer. To get there, the bench first sets the flag with one falling edge. It then raises the pin, drops it again and counts exactly two clock edges before issuing the acknowledge. A second collision arises in level mode, where the held low level keeps raising events while the acknowledge is written. The reference model tracks the pin delay itself, so every cycle of both sequences is compared.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_MODE = 0;
  localparam int BIT_IE   = 1;
  localparam int BIT_ACK  = 2;
  localparam int BIT_FLAG = 3;
  localparam int BIT_PE   = 4;
  localparam int BIT_POL  = 5;

  typedef struct packed {
    logic pol;
    logic pe;
    logic ie;
    logic mode;
  } ctrl_t;
endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pinirq_detect.sv
module pinirq_detect
  import pinirq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  pin_s,
  input  logic  run_mode,
  input  ctrl_t ctrl,
  output logic  det_event
);
  logic prev_q;
  logic lvl_on, edge_on, pol_ok;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= pin_s;
  end

  always_comb begin
    lvl_on  = ctrl.pol ? pin_s : ~pin_s;
    edge_on = ctrl.pol ? (pin_s & ~prev_q) : (~pin_s & prev_q);
    pol_ok  = ~ctrl.pol | run_mode;
    det_event = ctrl.pe & pol_ok & (edge_on | (ctrl.mode & lvl_on));
  end
endmodule

// File: rtl/pinirq_csr.sv
module pinirq_csr
  import pinirq_pkg::*;
(
  input  logic             clk,
  input  logic             por,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             det_event,
  output ctrl_t            ctrl,
  output logic [REG_W-1:0] rd_data,
  output logic             irq
);
  localparam logic [REG_W-1:0] USED_MASK =
    (REG_W'(1) << BIT_POL) | (REG_W'(1) << BIT_PE) | (REG_W'(1) << BIT_ACK) |
    (REG_W'(1) << BIT_IE)  | (REG_W'(1) << BIT_MODE);

  ctrl_t ctrl_q;
  logic  pend_q;
  logic  ack_clr;
  logic  unused_wr;

  assign ack_clr   = wr_en & wr_data[BIT_ACK] & ~rst;
  assign unused_wr = ^(wr_data & ~USED_MASK);

  always_ff @(posedge clk) begin
    if (por || rst) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q.pol  <= wr_data[BIT_POL];
      ctrl_q.pe   <= wr_data[BIT_PE];
      ctrl_q.ie   <= wr_data[BIT_IE];
      ctrl_q.mode <= wr_data[BIT_MODE];
    end
  end

  always_ff @(posedge clk) begin
    if (por)            pend_q <= 1'b0;
    else if (det_event) pend_q <= 1'b1;
    else if (ack_clr)   pend_q <= 1'b0;
  end

  always_comb begin
    rd_data           = '0;
    rd_data[BIT_POL]  = ctrl_q.pol;
    rd_data[BIT_PE]   = ctrl_q.pe;
    rd_data[BIT_FLAG] = pend_q;
    rd_data[BIT_IE]   = ctrl_q.ie;
    rd_data[BIT_MODE] = ctrl_q.mode;
  end

  assign irq  = pend_q & ctrl_q.ie;
  assign ctrl = ctrl_q;

  a_r9_rise_needs_event: assert property (@(posedge clk) disable iff (por)
    $rose(pend_q) |-> $past(det_event));
  a_r9_fall_needs_ack: assert property (@(posedge clk) disable iff (por)
    $fell(pend_q) |-> ($past(ack_clr) || $past(por)));
  a_r10_event_beats_ack: assert property (@(posedge clk) disable iff (por)
    (det_event && ack_clr) |=> pend_q);
  a_r2_flag_kept_on_rst: assert property (@(posedge clk) disable iff (por)
    (rst && pend_q) |=> pend_q);
endmodule

// File: rtl/pinirq_ctrl.sv
module pinirq_ctrl
  import pinirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             por,
  input  logic             rst,
  input  logic             run_mode,
  input  logic             pin_async,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             irq
);
  logic  any_rst;
  logic  pin_s;
  logic  det_event;
  ctrl_t ctrl;

  assign any_rst = por | rst;

  pinirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(any_rst), .d_async(pin_async), .d_sync(pin_s)
  );

  pinirq_detect u_det (
    .clk(clk), .rst(any_rst), .pin_s(pin_s), .run_mode(run_mode),
    .ctrl(ctrl), .det_event(det_event)
  );

  pinirq_csr u_csr (
    .clk(clk), .por(por), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .det_event(det_event), .ctrl(ctrl), .rd_data(rd_data), .irq(irq)
  );

  a_r6_no_rise_outside_run: assert property (@(posedge clk) disable iff (por)
    (ctrl.pol && !run_mode) |-> !det_event);
  a_r8_disabled_no_event: assert property (@(posedge clk) disable iff (por)
    !ctrl.pe |-> !det_event);
  a_r11_irq_needs_enable: assert property (@(posedge clk) disable iff (por)
    irq |-> rd_data[BIT_IE] && rd_data[BIT_FLAG]);
endmodule

// File: tb/pinirq_ctrl_tb.sv
module pinirq_ctrl_tb;
  logic clk = 1'b0;
  logic por = 1'b1, rst = 1'b1, run_mode = 1'b0, pin_async = 1'b1, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic irq;

  int checks = 0, fails = 0;
  bit checking = 0, done = 0;
  string cur_req = "R1";

  // reference state
  bit m_pol, m_pe, m_ie, m_mode, m_flag;
  bit hist[$];

  always #4 clk = ~clk;

  pinirq_ctrl u_dut (
    .clk(clk), .por(por), .rst(rst), .run_mode(run_mode), .pin_async(pin_async),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  // behavioural model: hist[k] is the pin value seen k+1 edges ago
  always @(posedge clk) begin
    bit now_v, old_v, active, edge_seen, ev, ack;
    if (por) begin
      {m_pol, m_pe, m_ie, m_mode, m_flag} = '0;
      hist = '{0, 0, 0};
    end else begin
      now_v = hist[1];
      old_v = hist[2];
      active    = m_pol ? now_v : !now_v;
      edge_seen = active && (m_pol ? !old_v : old_v);
      ev  = m_pe && (!m_pol || run_mode) && (edge_seen || (m_mode && active));
      ack = wr_en && wr_data[2] && !rst;
      if (ev) m_flag = 1;
      else if (ack) m_flag = 0;
      if (rst) begin
        {m_pol, m_pe, m_ie, m_mode} = '0;
        hist = '{0, 0, 0};
      end else begin
        if (wr_en) begin
          m_pol = wr_data[5]; m_pe = wr_data[4]; m_ie = wr_data[1]; m_mode = wr_data[0];
        end
        hist.push_front(pin_async);
        void'(hist.pop_back());
      end
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      logic [7:0] exp_rd;
      exp_rd = {2'b00, m_pol, m_pe, m_flag, 1'b0, m_ie, m_mode};
      checks++;
      if (rd_data !== exp_rd || irq !== (m_flag && m_ie)) begin
        fails++;
        $display("FAIL %s rd_data=%02h expected=%02h irq=%0b expected=%0b",
                 cur_req, rd_data, exp_rd, irq, m_flag && m_ie);
      end
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  // a directed check at a point the requirement names
  task automatic expect_flag(string req, bit exp);
    checks++;
    if (rd_data[3] !== exp) begin
      fails++;
      $display("FAIL %s flag=%0b expected=%0b", req, rd_data[3], exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R0 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(posedge clk); @(negedge clk);
    checking = 1;
    tick(3);
    cur_req = "R1"; por = 1'b0; rst = 1'b0;
    tick(3);
    expect_flag("R1", 0);

    // R3: layout, reads of bits 7:6 and 2, run_mode low blocks rising
    cur_req = "R3"; wr(8'hFF); tick(4); wr(8'h00); tick(2);

    // R4 falling edge, R12 no re-set while held low after ack
    cur_req = "R4"; wr(8'h12);
    pin_async = 1'b0; tick(2); expect_flag("R4", 0); tick(1); expect_flag("R4", 1);
    cur_req = "R12"; wr(8'h16); tick(5); expect_flag("R12", 0);

    // R9 flag bit and zero ack ignored
    cur_req = "R9"; pin_async = 1'b1; tick(4); pin_async = 1'b0; tick(4);
    wr(8'h1A); tick(1); expect_flag("R9", 1);
    wr(8'h12); tick(1); expect_flag("R9", 1);
    wr(8'h16); expect_flag("R9", 0); tick(2);

    // R11 gating by enable
    cur_req = "R11"; wr(8'h10); pin_async = 1'b1; tick(4); pin_async = 1'b0; tick(4);
    wr(8'h12); tick(2); wr(8'h14); tick(2);

    // R5 rising edge in run mode
    cur_req = "R5"; run_mode = 1'b1; wr(8'h32);
    pin_async = 1'b1; tick(4); expect_flag("R5", 1); wr(8'h36); tick(2);

    // R6 rising/high outside run mode
    cur_req = "R6"; run_mode = 1'b0; pin_async = 1'b0; tick(4);
    pin_async = 1'b1; tick(5); expect_flag("R6", 0);
    wr(8'h33); tick(5); expect_flag("R6", 0);

    // R7 level mode re-sets after ack
    cur_req = "R7"; wr(8'h13); pin_async = 1'b0; tick(4); expect_flag("R7", 1);
    wr(8'h17); tick(1); expect_flag("R7", 1);
    pin_async = 1'b1; tick(4); wr(8'h17); tick(2); expect_flag("R7", 0);

    // R8 pin disabled
    cur_req = "R8"; wr(8'h03); pin_async = 1'b0; tick(4); pin_async = 1'b1; tick(4);
    expect_flag("R8", 0);

    // R10 edge event lands in the same cycle as the ack
    cur_req = "R10"; wr(8'h12); pin_async = 1'b0; tick(4); expect_flag("R10", 1);
    pin_async = 1'b1; tick(4);
    pin_async = 1'b0; tick(2); wr(8'h16); expect_flag("R10", 1); tick(3);

    // R2 general reset keeps flag, por clears it
    cur_req = "R2"; rst = 1'b1; tick(2); rst = 1'b0; tick(2); expect_flag("R2", 1);
    cur_req = "R1"; por = 1'b1; tick(2); por = 1'b0; tick(2); expect_flag("R1", 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule